// File: doc/BRIEF.md
# Fault Supervisor With Auto-Retry

This block watches the protection flags of a half-bridge driver. Each flag arrives as a single bit from an analog comparator or a start-up check. Every flag has its own qualification rule. Some must persist for a set number of clock cycles, some act at once, and some count only in a given start-up phase. When any fault qualifies, switching stops at the next clock edge and the shared disable/fault pin is pulled low.

While the pin is held, the block sends a fault code by toggling the pull-down. The code is a burst of 1 to 9 pulses, and the pulse count names the fault. After the burst the pull-down stays on and a low-power indication is raised. A fixed time after fault entry the pin is let go. Once the pin reads high again, the block repeats the start-up check with every flag re-qualified. Switching resumes only if nothing is found, so the loop keeps retrying until the faults clear. A failed memory sanity check overrides everything else and persists until power-on reset.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, `sw_enable`, `pull_down` and `low_power` are 0. `sw_enable` rises only when all of the following hold:
  - at least CHECK_CYC cycles have been spent in the check phase;
  - the memory check has passed;
  - `prog_done` is 1;
  - `pin_sense` is 1;
  - no fault qualifies.
- R2: Low-side overcurrent (code 1) qualifies when `ls_oc_flag` has been high during `ls_on` for LSOC_CYC cycles in total. The count holds while `ls_on` is 0 and clears when the flag is low during `ls_on`. `ls_oc_off` = 1 disables this fault.
- R3: Severe overcurrent (code 2) qualifies after SEVOC_CYC consecutive cycles of `sev_oc_flag`. Any low cycle restarts the count.
- R4: Input overvoltage (code 4) qualifies after OV_CYC consecutive cycles of `ov_flag`. Any low cycle restarts the count.
- R5: Overtemperature (code 3), configuration-pin short (code 6) and timing-pin short (code 8) qualify in the first cycle their flag is sampled high.
- R6: Configuration-pin open (code 5) counts only while `prog_done` is 1. Out-of-range (code 7) counts only while `prog_busy` is 1.
- R7: A memory check that reports failure (`mem_chk_done` and `mem_chk_fail` both 1) latches code 9. From then on, every other fault is ignored, each retry reports code 9 again, and switching never starts until reset.
- R8: At the clock edge where a fault qualifies, `sw_enable` goes to 0 and `pull_down` goes to 1.
- R9: The fault code is N high pulses on `pull_down`, each PULSE_CYC cycles long, separated by low gaps of GAP_CYC cycles. The first pulse starts at fault entry.
- R10: When several faults qualify in the same cycle, the lowest code is reported.
- R11: After the burst, `pull_down` and `low_power` are both held at 1. `pull_down` is released exactly RETRY_CYC cycles after fault entry, and `low_power` stays 1 until the retry begins.
- R12: After release, the block waits for `pin_sense` to be 1 and then re-enters the check phase. A fault found there starts a new burst. Otherwise switching resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| ls_on | input | 1 | Low-side switch on-time window |
| ls_oc_flag | input | 1 | Low-side overcurrent comparator |
| ls_oc_off | input | 1 | Disables the low-side overcurrent fault |
| sev_oc_flag | input | 1 | Severe overcurrent on either switch |
| ot_flag | input | 1 | Overtemperature |
| ov_flag | input | 1 | Input overvoltage |
| cfg_open_flag | input | 1 | Configuration pin above the open level |
| cfg_short_flag | input | 1 | Configuration pin shorted low |
| cfg_range_flag | input | 1 | Configuration pin between the upper levels |
| rt_short_flag | input | 1 | Timing pin shorted low |
| mem_chk_done | input | 1 | Memory sanity check result is valid (pulse) |
| mem_chk_fail | input | 1 | Memory sanity check failed |
| prog_busy | input | 1 | Configuration programming check in progress |
| prog_done | input | 1 | Configuration programming check complete |
| pin_sense | input | 1 | Disable/fault pin is above the enable level |
| sw_enable | output | 1 | Switching permitted |
| pull_down | output | 1 | Pull-down enable for the disable/fault pin |
| low_power | output | 1 | Low-consumption indication after the code is sent |

## Verification
Qualification and entry timing are checked cycle by cycle:
- A flag with an L-cycle qualification time that rises before clock edge k stops switching after edge k+L-1.
- An immediate flag stops switching after the first edge that samples it.

The bench drives inputs on falling edges and reads `sw_enable` one falling edge before and one after the expected edge. Burst timing is checked by a monitor that samples `pull_down` and `low_power` on every falling edge. It measures each pulse (PULSE_CYC) and each inner gap (GAP_CYC), and counts pulses until `low_power` rises. It then compares the count with the code queued by the driver. Finally it checks that the pin is released exactly RETRY_CYC samples after the first pulse.

// File: rtl/fs_pkg.sv
package fs_pkg;

    localparam int unsigned NFAULT = 9;
    localparam int unsigned CODE_W = 4;

    typedef enum logic [2:0] {
        ST_CHECK   = 3'd0,
        ST_RUN     = 3'd1,
        ST_BURST   = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RELEASE = 3'd4
    } fs_state_e;

    // bit i of the hit vector carries fault code i+1
    localparam int unsigned IX_LSOC  = 0;
    localparam int unsigned IX_SEVOC = 1;
    localparam int unsigned IX_OT    = 2;
    localparam int unsigned IX_OV    = 3;
    localparam int unsigned IX_OPEN  = 4;
    localparam int unsigned IX_SHORT = 5;
    localparam int unsigned IX_RANGE = 6;
    localparam int unsigned IX_RT    = 7;
    localparam int unsigned IX_MEM   = 8;

    // lowest set bit wins; result is the pulse count
    function automatic logic [CODE_W-1:0] fs_pick(input logic [NFAULT-1:0] h);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int i = NFAULT - 1; i >= 0; i--) begin
            if (h[i]) r = CODE_W'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/fs_qual.sv
module fs_qual #(
    parameter int unsigned LIMIT         = 4,
    parameter bit          HOLD_OFF_GATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic gate,
    input  logic flag,
    output logic hit
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (!gate) begin
            if (!HOLD_OFF_GATE) cnt_d = '0;
        end else if (flag) begin
            if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    assign hit = !clr && gate && flag && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/fs_burst.sv
module fs_burst
    import fs_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 4,
    parameter int unsigned GAP_CYC   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              pd,
    output logic              busy
);
    localparam int unsigned LONGEST = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
    localparam int unsigned CW = $clog2(LONGEST + 1);
    localparam logic [CW-1:0] P_LAST = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] G_LAST = CW'(GAP_CYC - 1);

    typedef struct packed {
        logic              busy;
        logic              on;
        logic [CW-1:0]     cnt;
        logic [CODE_W-1:0] left;
    } burst_t;

    burst_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (load) begin
            b_d.busy = (code != '0);
            b_d.on   = 1'b1;
            b_d.cnt  = '0;
            b_d.left = code;
        end else if (b_q.busy) begin
            if (b_q.on) begin
                if (b_q.cnt == P_LAST) begin
                    b_d.on  = 1'b0;
                    b_d.cnt = '0;
                end else begin
                    b_d.cnt = b_q.cnt + 1'b1;
                end
            end else begin
                if (b_q.cnt == G_LAST) begin
                    b_d.cnt = '0;
                    b_d.on  = 1'b1;
                    if (b_q.left <= CODE_W'(1)) b_d.busy = 1'b0;
                    else                        b_d.left = b_q.left - 1'b1;
                end else begin
                    b_d.cnt = b_q.cnt + 1'b1;
                end
            end
        end
    end

    assign pd   = b_q.busy && b_q.on;
    assign busy = b_q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fs_pkg::*;
#(
    parameter int unsigned LSOC_CYC  = 420000,
    parameter int unsigned SEVOC_CYC = 21,
    parameter int unsigned OV_CYC    = 261,
    parameter int unsigned CHECK_CYC = 200,
    parameter int unsigned PULSE_CYC = 1000000,
    parameter int unsigned GAP_CYC   = 1000000,
    parameter int unsigned RETRY_CYC = 20000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ls_on,
    input  logic ls_oc_flag,
    input  logic ls_oc_off,
    input  logic sev_oc_flag,
    input  logic ot_flag,
    input  logic ov_flag,
    input  logic cfg_open_flag,
    input  logic cfg_short_flag,
    input  logic cfg_range_flag,
    input  logic rt_short_flag,
    input  logic mem_chk_done,
    input  logic mem_chk_fail,
    input  logic prog_busy,
    input  logic prog_done,
    input  logic pin_sense,
    output logic sw_enable,
    output logic pull_down,
    output logic low_power
);
    localparam int unsigned NQ    = 3;
    localparam int unsigned CHK_W = $clog2(CHECK_CYC + 1);
    localparam int unsigned RET_W = $clog2(RETRY_CYC + 1);
    localparam logic [CHK_W-1:0] CHK_LAST = CHK_W'(CHECK_CYC - 1);
    localparam logic [RET_W-1:0] RET_LAST = RET_W'(RETRY_CYC - 1);
    localparam int unsigned QLIM [NQ] = '{LSOC_CYC, SEVOC_CYC, OV_CYC};

    typedef struct packed {
        fs_state_e         state;
        logic [CHK_W-1:0]  chk;
        logic [RET_W-1:0]  ret;
        logic              mem_done;
        logic              mem_fail;
    } sup_t;

    sup_t s_d, s_q;

    logic              qual_on;
    logic [NQ-1:0]     q_flag, q_gate, q_clr, q_hit;
    logic [NFAULT-1:0] raw, hit;
    logic              load;
    logic [CODE_W-1:0] code_d;
    logic              burst_pd, burst_busy;

    assign qual_on = (s_q.state == ST_CHECK) || (s_q.state == ST_RUN);

    assign q_flag = {ov_flag, sev_oc_flag, ls_oc_flag};
    assign q_gate = {1'b1, 1'b1, ls_on};
    assign q_clr  = {!qual_on, !qual_on, !qual_on || ls_oc_off};

    // index 0 keeps its count outside its gate window
    for (genvar g = 0; g < NQ; g++) begin : g_qual
        fs_qual #(
            .LIMIT         (QLIM[g]),
            .HOLD_OFF_GATE (g == 0)
        ) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (q_clr[g]),
            .gate  (q_gate[g]),
            .flag  (q_flag[g]),
            .hit   (q_hit[g])
        );
    end

    always_comb begin
        raw           = '0;
        raw[IX_LSOC]  = q_hit[0];
        raw[IX_SEVOC] = q_hit[1];
        raw[IX_OT]    = ot_flag;
        raw[IX_OV]    = q_hit[2];
        raw[IX_OPEN]  = cfg_open_flag && prog_done;
        raw[IX_SHORT] = cfg_short_flag;
        raw[IX_RANGE] = cfg_range_flag && prog_busy;
        raw[IX_RT]    = rt_short_flag;
        if (!qual_on) begin
            hit = '0;
        end else if (s_q.mem_fail) begin
            hit         = '0;
            hit[IX_MEM] = 1'b1;
        end else begin
            hit = raw;
        end
    end

    always_comb begin
        s_d    = s_q;
        load   = 1'b0;
        code_d = fs_pick(hit);
        if (mem_chk_done) begin
            s_d.mem_done = 1'b1;
            if (mem_chk_fail) s_d.mem_fail = 1'b1;
        end
        unique case (s_q.state)
            ST_CHECK: begin
                if (s_q.chk != CHK_LAST) s_d.chk = s_q.chk + 1'b1;
                if (|hit) begin
                    load = 1'b1;
                end else if ((s_q.chk == CHK_LAST) && s_q.mem_done && !s_q.mem_fail
                             && prog_done && pin_sense) begin
                    s_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (|hit) load = 1'b1;
            end
            ST_BURST: begin
                if (s_q.ret != RET_LAST) s_d.ret = s_q.ret + 1'b1;
                if (!burst_busy) s_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (s_q.ret != RET_LAST) s_d.ret = s_q.ret + 1'b1;
                else                     s_d.state = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (pin_sense) begin
                    s_d.state = ST_CHECK;
                    s_d.chk   = '0;
                end
            end
            default: s_d.state = ST_CHECK;
        endcase
        if (load) begin
            s_d.state = ST_BURST;
            s_d.ret   = '0;
        end
    end

    fs_burst #(
        .PULSE_CYC (PULSE_CYC),
        .GAP_CYC   (GAP_CYC)
    ) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .code  (code_d),
        .pd    (burst_pd),
        .busy  (burst_busy)
    );

    assign sw_enable = (s_q.state == ST_RUN);
    assign pull_down = ((s_q.state == ST_BURST) && burst_pd) || (s_q.state == ST_HOLD);
    assign low_power = (s_q.state == ST_HOLD) || (s_q.state == ST_RELEASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= ST_CHECK;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_enable,
    input logic pull_down,
    input logic low_power,
    input logic pin_sense,
    input logic ot_flag,
    input logic cfg_short_flag,
    input logic mem_chk_done,
    input logic mem_chk_fail
);
    logic mem_bad_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           mem_bad_q <= 1'b0;
        else if (mem_chk_done && mem_chk_fail) mem_bad_q <= 1'b1;
    end

    // R8
    sw_pd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_enable && pull_down));

    // R5
    ot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_enable && ot_flag |=> !sw_enable && pull_down);

    // R5
    short_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_enable && cfg_short_flag |=> !sw_enable);

    // R11
    lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power) |-> pull_down);

    // R12
    resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_enable) |-> $past(pin_sense) && !$past(low_power));

    // R7
    mem_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_bad_q |-> !sw_enable);

endmodule

bind fault_supervisor fault_supervisor_chk u_chk (.*);

// File: tb/tb_fault_supervisor.sv
`timescale 1ns/1ps
module tb_fault_supervisor;
    localparam int LSOC = 20, SEVOC = 3, OVC = 6, CHK = 8, PC = 4, GC = 3, RET = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ls_on = 0, ls_oc_flag = 0, ls_oc_off = 0, sev_oc_flag = 0, ot_flag = 0, ov_flag = 0;
    logic cfg_open_flag = 0, cfg_short_flag = 0, cfg_range_flag = 0, rt_short_flag = 0;
    logic mem_chk_done = 0, mem_chk_fail = 0, prog_busy = 0, prog_done = 0;
    logic ext_hold = 0;
    logic pin_sense, sw_enable, pull_down, low_power;

    assign pin_sense = !pull_down && !ext_hold;

    always #2.5 clk = ~clk;

    fault_supervisor #(
        .LSOC_CYC(LSOC), .SEVOC_CYC(SEVOC), .OV_CYC(OVC), .CHECK_CYC(CHK),
        .PULSE_CYC(PC), .GAP_CYC(GC), .RETRY_CYC(RET)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ls_on(ls_on), .ls_oc_flag(ls_oc_flag), .ls_oc_off(ls_oc_off),
        .sev_oc_flag(sev_oc_flag), .ot_flag(ot_flag), .ov_flag(ov_flag),
        .cfg_open_flag(cfg_open_flag), .cfg_short_flag(cfg_short_flag),
        .cfg_range_flag(cfg_range_flag), .rt_short_flag(rt_short_flag),
        .mem_chk_done(mem_chk_done), .mem_chk_fail(mem_chk_fail),
        .prog_busy(prog_busy), .prog_done(prog_done), .pin_sense(pin_sense),
        .sw_enable(sw_enable), .pull_down(pull_down), .low_power(low_power)
    );

    int vectors = 0, errors = 0, bursts_seen = 0, nb = 0;
    int exp_q[$];
    bit done_flag = 0;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ncyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_code(input int c);
        exp_q.push_back(c);
        nb++;
    endtask

    task automatic wait_bursts(input string req);
        int t = 0;
        while (bursts_seen < nb && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(req, bursts_seen, nb);
    endtask

    task automatic wait_run(input string req);
        int t = 0;
        while (!sw_enable && t < 1000) begin
            @(negedge clk);
            t++;
        end
        chk(req, sw_enable, 1);
    endtask

    task automatic finish_up;
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // scoreboard monitor: burst shape, code count, release time
    logic prev_pd = 0, prev_lp = 0;
    bit   in_burst = 0;
    int   pcnt = 0, hi_len = 0, lo_len = 0, since = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            in_burst = 0; prev_pd = 0; prev_lp = 0;
        end else begin
            if (in_burst) since++;
            if (!prev_pd && pull_down && !low_power) begin
                if (!in_burst) begin
                    in_burst = 1; since = 0; pcnt = 1;
                end else begin
                    pcnt++;
                    chk("R9 gap length", lo_len, GC);
                end
                hi_len = 0;
            end
            if (pull_down && !low_power) hi_len++;
            if (prev_pd && !pull_down && !low_power && in_burst) begin
                chk("R9 pulse length", hi_len, PC);
                lo_len = 0;
            end
            if (!pull_down && !low_power && in_burst) lo_len++;
            if (!prev_lp && low_power && in_burst) begin
                if (exp_q.size() == 0) chk("R9 unexpected burst", pcnt, 0);
                else chk("R9 R10 pulse count", pcnt, exp_q.pop_front());
                chk("R11 pin held with low power", pull_down, 1);
            end
            if (prev_pd && !pull_down && low_power && in_burst) begin
                chk("R11 release time", since, RET);
                in_burst = 0;
                bursts_seen++;
            end
            prev_pd = pull_down;
            prev_lp = low_power;
        end
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_up();
    end

    initial begin
        ncyc(3);
        chk("R1 reset sw_enable", sw_enable, 0);
        chk("R1 reset pull_down", pull_down, 0);
        chk("R1 reset low_power", low_power, 0);
        rst_n = 1;
        prog_busy = 1;
        cfg_open_flag = 1;
        ncyc(12);
        chk("R6 open ignored before done", pull_down, 0);
        chk("R1 no switching before prog done", sw_enable, 0);
        cfg_open_flag = 0;
        // R6 out-of-range during programming check
        push_code(7);
        cfg_range_flag = 1;
        ncyc(1);
        chk("R6 range fault entry", pull_down, 1);
        cfg_range_flag = 0; prog_busy = 0; prog_done = 1;
        mem_chk_done = 1;
        ncyc(1);
        mem_chk_done = 0;
        wait_bursts("R11 first release");
        wait_run("R12 resume after clear");
        // R6 range ignored after the check
        cfg_range_flag = 1;
        ncyc(5);
        chk("R6 range ignored in run", sw_enable, 1);
        cfg_range_flag = 0;
        // R3 dropout then qualify
        sev_oc_flag = 1; ncyc(SEVOC - 1); sev_oc_flag = 0; ncyc(1);
        chk("R3 dropout restarts", sw_enable, 1);
        push_code(2);
        sev_oc_flag = 1;
        ncyc(SEVOC - 1);
        chk("R3 not yet", sw_enable, 1);
        ncyc(1);
        chk("R8 sw stops", sw_enable, 0);
        chk("R8 pull_down on", pull_down, 1);
        sev_oc_flag = 0;
        wait_bursts("R3 burst done");
        wait_run("R12 resume");
        // R2 low-side overcurrent
        ls_on = 1; ls_oc_flag = 1; ls_oc_off = 1;
        ncyc(30);
        chk("R2 disabled", sw_enable, 1);
        ls_oc_off = 0;
        ncyc(15);
        ls_oc_flag = 0; ncyc(1); ls_oc_flag = 1;
        ncyc(12);
        ls_on = 0; ncyc(10);
        ls_on = 1; ncyc(LSOC - 12 - 1);
        chk("R2 held count not yet", sw_enable, 1);
        push_code(1);
        ncyc(1);
        chk("R2 accumulated fault", sw_enable, 0);
        ls_on = 0; ls_oc_flag = 0;
        wait_bursts("R2 burst done");
        wait_run("R12 resume");
        // R4 overvoltage
        ov_flag = 1; ncyc(OVC - 1); ov_flag = 0; ncyc(1);
        chk("R4 dropout restarts", sw_enable, 1);
        push_code(4);
        ov_flag = 1; ncyc(OVC - 1);
        chk("R4 not yet", sw_enable, 1);
        ncyc(1);
        chk("R4 fault", sw_enable, 0);
        ov_flag = 0;
        wait_bursts("R4 burst done");
        wait_run("R12 resume");
        // R10 priority and R12 repeated retry
        push_code(3); push_code(3);
        ot_flag = 1; rt_short_flag = 1;
        ncyc(1);
        chk("R5 immediate overtemp", sw_enable, 0);
        nb--;
        wait_bursts("R12 first of two");
        nb++;
        while (!pull_down) @(negedge clk);
        ot_flag = 0; rt_short_flag = 0;
        wait_bursts("R12 retry burst");
        wait_run("R12 resume");
        // R5 shorts
        push_code(6);
        cfg_short_flag = 1; ncyc(1);
        chk("R5 cfg short", sw_enable, 0);
        cfg_short_flag = 0;
        wait_bursts("R5 short burst");
        wait_run("R12 resume");
        push_code(8);
        rt_short_flag = 1; ncyc(1);
        chk("R5 timing short", sw_enable, 0);
        rt_short_flag = 0;
        wait_bursts("R5 rt burst");
        wait_run("R12 resume");
        push_code(5);
        cfg_open_flag = 1; ncyc(1);
        chk("R6 open after done", sw_enable, 0);
        cfg_open_flag = 0;
        wait_bursts("R6 open burst");
        wait_run("R12 resume");
        // R7 memory failure
        rst_n = 0; ncyc(2); rst_n = 1;
        mem_chk_done = 1; mem_chk_fail = 1;
        ncyc(1);
        mem_chk_done = 0; mem_chk_fail = 0;
        ot_flag = 1; ext_hold = 1;
        push_code(9);
        wait_bursts("R7 first code");
        ncyc(20);
        chk("R12 waits for pin low_power", low_power, 1);
        chk("R12 waits for pin sw", sw_enable, 0);
        chk("R12 pin released", pull_down, 0);
        ot_flag = 0;
        push_code(9);
        ext_hold = 0;
        wait_bursts("R7 repeat code");
        ncyc(30);
        chk("R7 no switching", sw_enable, 0);
        push_code(9);
        wait_bursts("R7 still locked");
        rst_n = 0; ncyc(2); rst_n = 1;
        mem_chk_done = 1; ncyc(1); mem_chk_done = 0;
        wait_run("R7 cleared by reset");
        chk("R9 queue drained", exp_q.size(), 0);
        finish_up();
    end
endmodule